// File: doc/BRIEF.md
# Return Address Stack Predictor

This block supplies predicted targets for subroutine return instructions at the fetch stage. Each time fetch sees a call, the block records the address of the instruction that follows that call. When fetch later sees a return, the most recently recorded address is removed and offered as the predicted target, together with a valid flag. Calls and returns are therefore paired in last-in first-out order, which suits return instructions: the same return can go back to many call sites, so one stored target per branch would not work. Call targets are not handled here; they are direct and come from the branch target buffer.

The storage is a ring of entries with a top pointer and an occupancy count. When the ring is full, a further call overwrites the oldest entry. A return on an empty stack gives no prediction. A call and a return in the same cycle are both defined, and a synchronous flush discards every entry. Decode or the target buffer's type field identifies calls and returns. Recovery after a misprediction is handled elsewhere.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: a return gives pred_valid_o = 0 and pred_target_o = 0.
- R2: A call pushes call_pc_i + 4. A later return, with no other operation between them, gives pred_valid_o = 1 and pred_target_o equal to that value in the same cycle as the return.
- R3: Nested calls are predicted in reverse order: returns yield the pushed values newest first, and each return removes one entry.
- R4: A return on an empty stack gives pred_valid_o = 0 and changes no state, so later calls and returns behave as if it never occurred.
- R5: The stack holds DEPTH = 8 entries. A push on a full stack overwrites the oldest entry and occupancy stays at 8. After 9 pushes, 8 returns give the 9th through 2nd values, and a 9th return gives pred_valid_o = 0.
- R6: A call and a return in the same cycle on a non-empty stack predict the current top. The top entry is then replaced by call_pc_i + 4 and occupancy does not change.
- R7: A call and a return in the same cycle on an empty stack give pred_valid_o = 0 and push call_pc_i + 4 as a plain call would.
- R8: flush_i takes priority over call_i and ret_i. In the flush cycle pred_valid_o = 0, and afterwards the stack is empty.
- R9: pred_valid_o is 0 in every cycle where ret_i is 0, and pred_target_o is 0 whenever pred_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of all entries |
| call_i | input | 1 | Fetched instruction is a call |
| call_pc_i | input | ADDR_W | Address of the call instruction |
| ret_i | input | 1 | Fetched instruction is a return |
| pred_valid_o | output | 1 | Predicted return target is valid |
| pred_target_o | output | ADDR_W | Predicted return target |

## Verification
The bench runs a queue-based model in lockstep with the design and checks every cycle. Shallow call/return pairs confirm the +4 offset and the same-cycle prediction. Deep nesting and runs of more than eight calls separate correct LIFO order from wrong pointer wrap or count saturation. Returns on an empty stack, same-cycle call and return on both empty and occupied stacks, and flushes that collide with calls and returns each exercise a separate priority or corner path, so a fault in any one of them shows up as a mismatch.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PW-1:0]     wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PW-1:0]     rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == PW'(g))) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  ras_op_e       op_i,
  output logic          empty_o,
  output logic [PW-1:0] top_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_idx_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] top_q, top_d, up_idx, dn_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty, full;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == FULL);
  assign up_idx = (top_q == LAST) ? '0 : top_q + PW'(1);
  assign dn_idx = (top_q == '0) ? LAST : top_q - PW'(1);

  always_comb begin
    top_d    = top_q;
    cnt_d    = cnt_q;
    wr_en_o  = 1'b0;
    wr_idx_o = top_q;
    if (flush_i) begin
      cnt_d = '0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          wr_en_o  = 1'b1;
          wr_idx_o = up_idx;
          top_d    = up_idx;
          cnt_d    = full ? cnt_q : cnt_q + CW'(1);
        end
        OP_POP: begin
          if (!empty) begin
            top_d = dn_idx;
            cnt_d = cnt_q - CW'(1);
          end
        end
        OP_SWAP: begin
          wr_en_o = 1'b1;
          if (empty) begin
            wr_idx_o = up_idx;
            top_d    = up_idx;
            cnt_d    = CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

  assign empty_o = empty;
  assign top_o   = top_q;

  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

  // R5
  full_push_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && op_i == OP_PUSH && full) |=> (cnt_q == FULL));

  // R2
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && op_i == OP_PUSH && !full) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R4
  empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && op_i == OP_POP && empty) |=> ($stable(top_q) && cnt_q == '0));

  // R6
  swap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && op_i == OP_SWAP && !empty) |=> ($stable(top_q) && $stable(cnt_q)));

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 8,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  input  logic              ret_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_target_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  ras_op_e           op;
  logic              empty, wr_en;
  logic [PW-1:0]     top_idx, wr_idx;
  logic [ADDR_W-1:0] top_data;

  always_comb begin
    unique case ({call_i, ret_i})
      2'b10:   op = OP_PUSH;
      2'b01:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_NONE;
    endcase
  end

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .op_i    (op),
    .empty_o (empty),
    .top_o   (top_idx),
    .wr_en_o (wr_en),
    .wr_idx_o(wr_idx)
  );

  ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(call_pc_i + STEP),
    .rd_idx_i (top_idx),
    .rd_data_o(top_data)
  );

  assign pred_valid_o  = ret_i && !flush_i && !empty;
  assign pred_target_o = pred_valid_o ? top_data : '0;

  // R9
  valid_only_on_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_i |-> !pred_valid_o);

  // R9
  target_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> (pred_target_o == '0));

  // R2
  push_then_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !flush_i) |=> (ret_i && !call_i && !flush_i) |->
      (pred_valid_o && pred_target_o == $past(call_pc_i) + STEP));
endmodule

// File: tb/sim_ret_addr_stack.sv
`timescale 1ns/1ps
module sim_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, call = 1'b0, ret = 1'b0;
  logic [31:0] pc = '0;
  logic        pv;
  logic [31:0] pt;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] model[$];

  always #2.5 clk = ~clk;

  ret_addr_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .call_i(call),
    .call_pc_i(pc), .ret_i(ret), .pred_valid_o(pv), .pred_target_o(pt)
  );

  task automatic step(input string req, input bit f, input bit c,
                      input logic [31:0] p, input bit r);
    logic        ev;
    logic [31:0] et;
    @(negedge clk);
    flush = f; call = c; pc = p; ret = r;
    #1;
    ev = r && !f && (model.size() > 0);
    et = ev ? model[model.size()-1] : 32'h0;
    checks++;
    if (pv !== ev || pt !== et) begin
      fails++;
      $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
               req, pv, pt, ev, et);
    end
    if (f) model.delete();
    else if (c && r) begin
      if (model.size() > 0) model[model.size()-1] = p + 32'd4;
      else model.push_back(p + 32'd4);
    end else if (c) begin
      model.push_back(p + 32'd4);
      if (model.size() > 8) void'(model.pop_front());
    end else if (r) begin
      if (model.size() > 0) void'(model.pop_back());
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0);
    step("R2", 0, 1, 32'h1000, 0);
    step("R9", 0, 0, 0, 0);
    step("R2", 0, 0, 0, 1);
    step("R4", 0, 0, 0, 1);
    // R3 nesting
    for (int i = 0; i < 5; i++) step("R3", 0, 1, 32'h2000 + 32'(i * 16), 0);
    for (int i = 0; i < 6; i++) step("R3", 0, 0, 0, 1);
    // R4 repeated empty pops then normal use
    step("R4", 0, 0, 0, 1);
    step("R4", 0, 1, 32'h3000, 0);
    step("R4", 0, 0, 0, 1);
    // R5 overflow
    for (int i = 0; i < 11; i++) step("R5", 0, 1, 32'h4000 + 32'(i * 8), 0);
    for (int i = 0; i < 9; i++) step("R5", 0, 0, 0, 1);
    // R6 swap on occupied stack
    step("R6", 0, 1, 32'h5000, 0);
    step("R6", 0, 1, 32'h5100, 0);
    step("R6", 0, 1, 32'h5200, 1);
    step("R6", 0, 0, 0, 1);
    step("R6", 0, 0, 0, 1);
    step("R6", 0, 0, 0, 1);
    // R7 swap on empty stack
    step("R7", 0, 1, 32'h6000, 1);
    step("R7", 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1);
    // R6 swap on full stack
    for (int i = 0; i < 8; i++) step("R6", 0, 1, 32'h7000 + 32'(i * 4), 0);
    step("R6", 0, 1, 32'h7F00, 1);
    for (int i = 0; i < 9; i++) step("R6", 0, 0, 0, 1);
    // R8 flush priority
    step("R8", 0, 1, 32'h8000, 0);
    step("R8", 0, 1, 32'h8100, 0);
    step("R8", 1, 1, 32'h8200, 1);
    step("R8", 0, 0, 0, 1);
    step("R8", 0, 1, 32'h8300, 0);
    step("R8", 1, 0, 0, 1);
    step("R8", 0, 0, 0, 1);
    // mixed pattern
    for (int i = 0; i < 40; i++)
      step("R3", 0, (i % 3) != 2, 32'h9000 + 32'(i * 4), (i % 4) == 3);
    for (int i = 0; i < 10; i++) step("R3", 0, 0, 0, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule